// File: doc/BRIEF.md
# SPI Command Frame Builder

This block turns one host command into the byte sequence a serial peripheral expects on its command phase. A command is presented as an opcode, an address, a 32-bit data word, a transfer size and a clockless flag. The block packs the fields the opcode calls for, streams the bytes out one per handshake on a valid/ready byte port, and closes the frame with a CRC7 check byte unless the CRC is switched off.

The command port is a valid/ready pair. While a frame is being streamed the block refuses further commands. The CRC is accumulated byte by byte as the body bytes are accepted downstream, so the check byte is ready the moment it is needed. A single-cycle done pulse marks the end of every frame. An opcode the block does not know produces a single-cycle error pulse and no bytes at all. The serial shifter, chip select timing and everything after the command phase are left to neighbouring logic.

Top module: `cmd_frame_builder`

## Requirements
- R1: After reset, out_valid, done and err are 0 and cmd_ready is 1.
- R2: A command is taken on a cycle with cmd_valid and cmd_ready both 1; cmd_ready stays 0 until the frame has finished, and while out_valid is 1 and out_ready is 0 the value of out_byte does not change.
- R3: For opcode 0xCA (single read) the frame starts with the opcode followed by cmd_addr[23:0], most significant byte first; for 0xC7 (block write) and 0xC8 (block read) the same address is followed by cmd_size[23:0], most significant byte first.
- R4: For opcodes 0xC3 and 0xC4 the opcode is followed by cmd_addr[15:8] then cmd_addr[7:0], with bit 7 of the high byte forced to 1 when cmd_clockless is 1; 0xC4 then sends one 0x00 byte and 0xC3 sends cmd_data most significant byte first. For all other opcodes cmd_clockless has no effect.
- R5: For opcode 0xC9 (single write) the opcode is followed by cmd_addr[23:0] and then cmd_data[31:0], both most significant byte first.
- R6: For opcode 0xCF (reset) the opcode is followed by three 0xFF bytes.
- R7: With CRC enabled the frame lengths are 5 bytes for 0xCA, 0xC4 and 0xCF; 8 bytes for 0xC3, 0xC7 and 0xC8; 9 bytes for 0xC9.
- R8: With CRC enabled the last byte holds in bits 7:1 the CRC7 (generator x^7+x^3+1, register seeded with 0x7F, bytes fed most significant bit first) of all preceding bytes of the frame, and bit 0 is 0.
- R9: crc_off is sampled when the command is taken; when it is 1 the check byte is not sent and the frame is one byte shorter than in R7.
- R10: done is 1 for exactly one cycle, the cycle after the handshake of the last frame byte, and the block is then ready for a new command.
- R11: An opcode outside 0xC3, 0xC4, 0xC7, 0xC8, 0xC9, 0xCA, 0xCF makes err 1 for the one cycle after the command is taken; no byte is offered and cmd_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_opcode | input | 8 | Command opcode |
| cmd_addr | input | 24 | Target address |
| cmd_data | input | 32 | Write data word |
| cmd_size | input | 24 | Block transfer size |
| cmd_clockless | input | 1 | Mark internal-register access as clockless |
| crc_off | input | 1 | Omit the trailing check byte |
| out_valid | output | 1 | Frame byte present |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | 8 | Frame byte |
| done | output | 1 | Frame finished pulse |
| err | output | 1 | Unsupported opcode pulse |

## Verification
On every cycle the assertions check the handshake rules: a held byte stays stable under backpressure, the command and byte ports are never both active, done and err follow only the handshakes that cause them, an error never coincides with an offered byte, and the beat count of each frame matches its expected length. Field packing per opcode, the clockless bit, the CRC value in the trailing byte and the shortened frame with CRC off can only be shown by the bench's scenarios, which compare every byte with a frame built from the requirements.

// File: rtl/cfb_pkg.sv
package cfb_pkg;
    localparam int ADDR_W     = 24;
    localparam int DATA_W     = 32;
    localparam int SIZE_W     = 24;
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int DATA_BYTES = DATA_W / 8;
    localparam int SIZE_BYTES = SIZE_W / 8;
    localparam int BODY_MAX   = 1 + ADDR_BYTES + DATA_BYTES;
    localparam int SEL_W      = $clog2(BODY_MAX);
    localparam int IDX_W      = $clog2(BODY_MAX + 2);
    localparam int CRC_W      = 7;

    typedef logic [7:0] byte_t;
    typedef byte_t [BODY_MAX-1:0] body_t;

    localparam byte_t OP_REG_WR   = 8'hC3;
    localparam byte_t OP_REG_RD   = 8'hC4;
    localparam byte_t OP_BLK_WR   = 8'hC7;
    localparam byte_t OP_BLK_RD   = 8'hC8;
    localparam byte_t OP_WORD_WR  = 8'hC9;
    localparam byte_t OP_WORD_RD  = 8'hCA;
    localparam byte_t OP_LINK_RST = 8'hCF;

    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

    function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] crc,
                                                   input byte_t data);
        logic [CRC_W-1:0] c;
        logic fb;
        c = crc;
        for (int i = 7; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ data[i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction
endpackage

// File: rtl/cfb_layout.sv
module cfb_layout
    import cfb_pkg::*;
(
    input  byte_t                 opcode,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     data,
    input  logic [SIZE_W-1:0]     size,
    input  logic                  clockless,
    output body_t                 body,
    output logic [IDX_W-1:0]      body_len,
    output logic                  supported
);
    byte_t reg_hi;

    always_comb begin
        reg_hi    = {addr[15] | clockless, addr[14:8]};
        body      = '0;
        body[0]   = opcode;
        body_len  = '0;
        supported = 1'b1;
        unique case (opcode)
            OP_WORD_RD: begin
                for (int i = 0; i < ADDR_BYTES; i++)
                    body[1+i] = addr[ADDR_W-1-8*i -: 8];
                body_len = IDX_W'(1 + ADDR_BYTES);
            end
            OP_BLK_WR, OP_BLK_RD: begin
                for (int i = 0; i < ADDR_BYTES; i++)
                    body[1+i] = addr[ADDR_W-1-8*i -: 8];
                for (int i = 0; i < SIZE_BYTES; i++)
                    body[1+ADDR_BYTES+i] = size[SIZE_W-1-8*i -: 8];
                body_len = IDX_W'(1 + ADDR_BYTES + SIZE_BYTES);
            end
            OP_WORD_WR: begin
                for (int i = 0; i < ADDR_BYTES; i++)
                    body[1+i] = addr[ADDR_W-1-8*i -: 8];
                for (int i = 0; i < DATA_BYTES; i++)
                    body[1+ADDR_BYTES+i] = data[DATA_W-1-8*i -: 8];
                body_len = IDX_W'(1 + ADDR_BYTES + DATA_BYTES);
            end
            OP_REG_RD: begin
                body[1]  = reg_hi;
                body[2]  = addr[7:0];
                body[3]  = 8'h00;
                body_len = IDX_W'(4);
            end
            OP_REG_WR: begin
                body[1] = reg_hi;
                body[2] = addr[7:0];
                for (int i = 0; i < DATA_BYTES; i++)
                    body[3+i] = data[DATA_W-1-8*i -: 8];
                body_len = IDX_W'(3 + DATA_BYTES);
            end
            OP_LINK_RST: begin
                body[1]  = 8'hFF;
                body[2]  = 8'hFF;
                body[3]  = 8'hFF;
                body_len = IDX_W'(4);
            end
            default: begin
                supported = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cfb_crc7.sv
module cfb_crc7
    import cfb_pkg::*;
#(
    parameter logic [CRC_W-1:0] SEED = 7'h7F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  byte_t            data,
    output logic [CRC_W-1:0] crc
);
    logic [CRC_W-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clear)
            crc_d = SEED;
        else if (en)
            crc_d = crc7_step(crc_q, data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= SEED;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

    // R8: a clear always reloads the seed on the next cycle
    assert_seed_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> crc_q == SEED);
endmodule

// File: rtl/cmd_frame_builder.sv
module cmd_frame_builder
    import cfb_pkg::*;
#(
    parameter logic [CRC_W-1:0] CRC_SEED = 7'h7F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [7:0]        cmd_opcode,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [SIZE_W-1:0] cmd_size,
    input  logic              cmd_clockless,
    input  logic              crc_off,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_byte,
    output logic              done,
    output logic              err
);
    typedef struct packed {
        logic             busy;
        body_t            body;
        logic [IDX_W-1:0] body_len;
        logic             crc_on;
        logic [IDX_W-1:0] idx;
        logic             done;
        logic             err;
    } state_t;

    state_t s_d, s_q;

    body_t            lay_body;
    logic [IDX_W-1:0] lay_len;
    logic             lay_ok;
    logic [CRC_W-1:0] crc_val;
    logic             crc_clr, crc_en;
    logic             in_body, last_beat;
    logic [IDX_W-1:0] frame_len;
    byte_t            body_byte;

    cfb_layout u_layout (
        .opcode    (cmd_opcode),
        .addr      (cmd_addr),
        .data      (cmd_data),
        .size      (cmd_size),
        .clockless (cmd_clockless),
        .body      (lay_body),
        .body_len  (lay_len),
        .supported (lay_ok)
    );

    cfb_crc7 #(.SEED(CRC_SEED)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (crc_clr),
        .en    (crc_en),
        .data  (body_byte),
        .crc   (crc_val)
    );

    assign frame_len = s_q.body_len + IDX_W'(s_q.crc_on);
    assign in_body   = s_q.idx < s_q.body_len;
    assign last_beat = s_q.idx == frame_len - IDX_W'(1);
    assign body_byte = s_q.body[s_q.idx[SEL_W-1:0]];

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        crc_clr  = 1'b0;
        crc_en   = 1'b0;
        if (!s_q.busy) begin
            if (cmd_valid) begin
                if (lay_ok) begin
                    s_d.busy     = 1'b1;
                    s_d.body     = lay_body;
                    s_d.body_len = lay_len;
                    s_d.crc_on   = !crc_off;
                    s_d.idx      = '0;
                    crc_clr      = 1'b1;
                end else begin
                    s_d.err = 1'b1;
                end
            end
        end else if (out_ready) begin
            crc_en = in_body;
            if (last_beat) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.idx = s_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_ready = !s_q.busy;
    assign out_valid = s_q.busy;
    assign out_byte  = in_body ? body_byte : {crc_val, 1'b0};
    assign done      = s_q.done;
    assign err       = s_q.err;

    // beat counter kept apart from the index, used only by the checks
    logic [IDX_W-1:0] beat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      beat_q <= '0;
        else if (cmd_valid && cmd_ready) beat_q <= '0;
        else if (out_valid && out_ready) beat_q <= beat_q + IDX_W'(1);
    end

    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_byte));

    assert_ports_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ready && out_valid));

    assert_done_after_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_ready) && cmd_ready);

    assert_err_no_bytes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(cmd_valid && cmd_ready) && !out_valid && cmd_ready);

    assert_frame_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> beat_q == s_q.body_len + IDX_W'(s_q.crc_on));
endmodule

// File: tb/cmd_frame_builder_bench.sv
`timescale 1ns/1ps
module cmd_frame_builder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  cmd_opcode = '0;
    logic [23:0] cmd_addr = '0;
    logic [31:0] cmd_data = '0;
    logic [23:0] cmd_size = '0;
    logic        cmd_clockless = 1'b0;
    logic        crc_off = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_byte;
    logic        done;
    logic        err;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    logic [7:0] exp_b [0:15];
    int         exp_n;

    always #2 clk = ~clk;

    cmd_frame_builder u_cmd_frame_builder (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_size(cmd_size), .cmd_clockless(cmd_clockless), .crc_off(crc_off),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc(input logic [6:0] c0, input logic [7:0] d);
        logic [6:0] c;
        logic fb;
        c = c0;
        for (int i = 7; i >= 0; i--) begin
            fb = c[6] ^ d[i];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'b0001001;
        end
        return c;
    endfunction

    task automatic build_exp(input logic [7:0] op, input logic [23:0] a,
                             input logic [31:0] d, input logic [23:0] s,
                             input logic ck, input logic coff);
        logic [6:0] c;
        exp_b[0] = op;
        case (op)
            8'hCA: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0]; exp_n=4; end
            8'hC7, 8'hC8: begin
                exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0];
                exp_b[4]=s[23:16]; exp_b[5]=s[15:8]; exp_b[6]=s[7:0]; exp_n=7;
            end
            8'hC9: begin
                exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0];
                exp_b[4]=d[31:24]; exp_b[5]=d[23:16]; exp_b[6]=d[15:8]; exp_b[7]=d[7:0];
                exp_n=8;
            end
            8'hC4: begin
                exp_b[1]={a[15]|ck, a[14:8]}; exp_b[2]=a[7:0]; exp_b[3]=8'h00; exp_n=4;
            end
            8'hC3: begin
                exp_b[1]={a[15]|ck, a[14:8]}; exp_b[2]=a[7:0];
                exp_b[3]=d[31:24]; exp_b[4]=d[23:16]; exp_b[5]=d[15:8]; exp_b[6]=d[7:0];
                exp_n=7;
            end
            default: begin exp_b[1]=8'hFF; exp_b[2]=8'hFF; exp_b[3]=8'hFF; exp_n=4; end
        endcase
        if (!coff) begin
            c = 7'h7F;
            for (int i = 0; i < exp_n; i++) c = ref_crc(c, exp_b[i]);
            exp_b[exp_n] = {c, 1'b0};
            exp_n++;
        end
    endtask

    task automatic run_frame(input logic [7:0] op, input logic [23:0] a,
                             input logic [31:0] d, input logic [23:0] s,
                             input logic ck, input logic coff, input bit stall,
                             input string req);
        logic [7:0] got [0:15];
        int n = 0;
        int cyc = 0;
        bit hold = 1'b0;
        logic [7:0] held = '0;
        build_exp(op, a, d, s, ck, coff);
        @(negedge clk);
        cmd_opcode = op; cmd_addr = a; cmd_data = d; cmd_size = s;
        cmd_clockless = ck; crc_off = coff; cmd_valid = 1'b1;
        chk(cmd_ready == 1'b1, "R2", "ready before command", 32'(cmd_ready), 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        crc_off = ~coff;
        while (cyc < 40 && out_valid) begin
            out_ready = stall ? (cyc % 3 != 0) : 1'b1;
            if (hold)
                chk(out_byte == held, "R2", "byte stable while stalled", 32'(out_byte), 32'(held));
            if (cmd_ready)
                chk(1'b0, "R2", "ready during frame", 1, 0);
            if (out_ready) begin
                if (n < 16) got[n] = out_byte;
                n++;
                hold = 1'b0;
            end else begin
                hold = 1'b1;
                held = out_byte;
            end
            cyc++;
            @(negedge clk);
        end
        chk(done == 1'b1, "R10", "done after last byte", 32'(done), 1);
        chk(cmd_ready == 1'b1 && out_valid == 1'b0, "R10", "idle after frame",
            32'({cmd_ready, out_valid}), 32'b10);
        chk(n == exp_n, coff ? "R9" : "R7", "frame length", 32'(n), 32'(exp_n));
        for (int i = 0; i < 16; i++) begin
            if (i < n && i < exp_n)
                chk(got[i] == exp_b[i], (!coff && i == exp_n - 1) ? "R8" : req,
                    $sformatf("byte %0d of op %0h", i, op), 32'(got[i]), 32'(exp_b[i]));
        end
        out_ready = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R10", "done one cycle only", 32'(done), 0);
    endtask

    task automatic t_reset;
        chk(out_valid == 1'b0, "R1", "out_valid at reset", 32'(out_valid), 0);
        chk(done == 1'b0, "R1", "done at reset", 32'(done), 0);
        chk(err == 1'b0, "R1", "err at reset", 32'(err), 0);
        chk(cmd_ready == 1'b1, "R1", "cmd_ready at reset", 32'(cmd_ready), 1);
    endtask

    task automatic t_bad_opcode(input logic [7:0] op);
        @(negedge clk);
        cmd_opcode = op; cmd_valid = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(err == 1'b1, "R11", $sformatf("err for op %0h", op), 32'(err), 1);
        chk(out_valid == 1'b0, "R11", "no byte on bad op", 32'(out_valid), 0);
        chk(cmd_ready == 1'b1, "R11", "ready stays high", 32'(cmd_ready), 1);
        @(negedge clk);
        chk(err == 1'b0, "R11", "err one cycle only", 32'(err), 0);
        for (int i = 0; i < 4; i++) begin
            chk(out_valid == 1'b0 && done == 1'b0, "R11", "no frame after bad op",
                32'({out_valid, done}), 0);
            @(negedge clk);
        end
        out_ready = 1'b0;
    endtask

    task automatic t_single_read;   run_frame(8'hCA, 24'h12_34_56, 32'h0, 24'h0, 1'b1, 1'b0, 1'b0, "R3"); endtask
    task automatic t_block_write;   run_frame(8'hC7, 24'hA5_00_3C, 32'h0, 24'h00_20_01, 1'b0, 1'b0, 1'b1, "R3"); endtask
    task automatic t_block_read;    run_frame(8'hC8, 24'h01_02_03, 32'hFFFF_FFFF, 24'hFE_DC_BA, 1'b0, 1'b0, 1'b0, "R3"); endtask
    task automatic t_reg_read;
        run_frame(8'hC4, 24'h00_0F_24, 32'h0, 24'h0, 1'b0, 1'b0, 1'b0, "R4");
        run_frame(8'hC4, 24'h00_0F_24, 32'h0, 24'h0, 1'b1, 1'b0, 1'b1, "R4");
    endtask
    task automatic t_reg_write;     run_frame(8'hC3, 24'hFF_10_30, 32'hDEAD_BEEF, 24'h0, 1'b1, 1'b0, 1'b0, "R4"); endtask
    task automatic t_word_write;    run_frame(8'hC9, 24'h00_10_00, 32'h0102_0304, 24'h0, 1'b1, 1'b0, 1'b1, "R5"); endtask
    task automatic t_link_reset;    run_frame(8'hCF, 24'h0, 32'h0, 24'h0, 1'b0, 1'b0, 1'b0, "R6"); endtask
    task automatic t_crc_off;
        run_frame(8'hC9, 24'h00_E8_24, 32'h0000_0050, 24'h0, 1'b0, 1'b1, 1'b0, "R9");
        run_frame(8'hCF, 24'h0, 32'h0, 24'h0, 1'b0, 1'b1, 1'b1, "R9");
        run_frame(8'hC8, 24'h00_00_10, 32'h0, 24'h00_00_02, 1'b0, 1'b1, 1'b0, "R9");
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_read();
        t_block_write();
        t_block_read();
        t_reg_read();
        t_reg_write();
        t_word_write();
        t_link_reset();
        t_crc_off();
        t_bad_opcode(8'hC5);
        t_bad_opcode(8'h00);
        t_single_read();
        finish_run();
    end
endmodule